// File: doc/BRIEF.md
# Text Cursor Gate

This block sits beside the character fetch path of a text-mode display and decides, for every cell and scanline, whether the text cursor covers that spot. The display engine supplies the memory address of the cell it is fetching, the scanline within the current character row, a display-enable flag and a one-cycle strobe once per frame. Software supplies a cursor address, a first and a last scanline that together form the cursor's shape, and a 2-bit mode.

The mode makes the cursor steady, hidden, or blinking at one of two rates. Both rates come from a free-running frame counter inside the block. The single output tells the pixel path to invert the cell. That output is registered and is valid one clock after its inputs.

Top module: `text_cursor_gate`

## Requirements
- R1: While reset is high, and in the cycle after it, `cursor_on` is 0. Reset also clears the frame counter to 0.
- R2: Mode 2'b00 is steady. `cursor_on` is 1 whenever the address, scanline and enable conditions hold, whatever the frame count is.
- R3: Mode 2'b01 is hidden. `cursor_on` stays 0 for every input pattern.
- R4: Mode 2'b10 is fast blink. The cursor may show only while the frame count modulo 16 is below 8.
- R5: Mode 2'b11 is slow blink. The cursor may show only while the frame count modulo 32 is below 16.
- R6: `cursor_on` is 0 whenever `cell_addr` differs from `cur_addr`.
- R7: The cursor shows only when `first_line <= scan_line <= last_line`, with both bounds included. If `first_line > last_line`, no scanline shows the cursor.
- R8: `cursor_on` is 0 whenever `disp_en` is 0.
- R9: `cursor_on` reflects the inputs sampled at the previous rising edge, which is one cycle of latency. A `frame_tick` sampled at an edge advances the frame count, and the new count takes effect from the next cycle's decision onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe per displayed frame |
| mode | input | 2 | Cursor mode: 00 steady, 01 hidden, 10 fast blink, 11 slow blink |
| first_line | input | 5 | First scanline of the cursor shape |
| last_line | input | 5 | Last scanline of the cursor shape |
| cur_addr | input | 16 | Display memory address holding the cursor |
| cell_addr | input | 16 | Display memory address of the cell being fetched |
| scan_line | input | 5 | Scanline within the current character row |
| disp_en | input | 1 | High while the beam is in the active display area |
| cursor_on | output | 1 | Invert the current cell at this scanline |

## Verification
Every decision appears at `cursor_on` one rising edge after its inputs are applied. A frame strobe changes the blink phase from the decision after the edge that samples it.

The driver applies each stimulus at a falling edge and queues the expected value, computed from its own model of the frame count. The monitor pops that value 5 ns after the following rising edge, so each comparison lands in exactly the cycle the result is due.

Blink checks run for more than one full period of each rate. These runs cover the boundaries at counts 8, 16 and 32.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

    typedef enum logic [1:0] {
        CM_STEADY = 2'b00,
        CM_HIDDEN = 2'b01,
        CM_FAST   = 2'b10,
        CM_SLOW   = 2'b11
    } cur_mode_e;

    typedef struct packed {
        logic addr_hit;
        logic line_hit;
        logic enabled;
    } cell_hit_t;

    typedef struct packed {
        logic fast_vis;
        logic slow_vis;
    } blink_phase_t;

    function automatic logic line_in_window(
        input logic [4:0] line,
        input logic [4:0] lo,
        input logic [4:0] hi
    );
        return (line >= lo) && (line <= hi);
    endfunction

endpackage

// File: rtl/tcg_blink_gen.sv
module tcg_blink_gen
    import tcg_pkg::*;
#(
    parameter int FAST_LOG2 = 4,
    parameter int SLOW_LOG2 = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_tick,
    output blink_phase_t phase
);
    localparam int CNT_W = (SLOW_LOG2 > FAST_LOG2) ? SLOW_LOG2 : FAST_LOG2;

    logic [CNT_W-1:0] frame_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt <= '0;
        end else if (frame_tick) begin
            frame_cnt <= frame_cnt + 1'b1;
        end
    end

    // first half of each period is visible
    always_comb begin
        phase.fast_vis = ~frame_cnt[FAST_LOG2-1];
        phase.slow_vis = ~frame_cnt[SLOW_LOG2-1];
    end

endmodule

// File: rtl/tcg_cell_match.sv
module tcg_cell_match
    import tcg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 5
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] cell_addr,
    input  logic [LINE_W-1:0] first_line,
    input  logic [LINE_W-1:0] last_line,
    input  logic [LINE_W-1:0] scan_line,
    input  logic              disp_en,
    output cell_hit_t         hit
);
    localparam int PAD = 5 - LINE_W;

    logic [4:0] ln, lo, hi;

    generate
        if (PAD > 0) begin : g_pad
            assign ln = {{PAD{1'b0}}, scan_line};
            assign lo = {{PAD{1'b0}}, first_line};
            assign hi = {{PAD{1'b0}}, last_line};
        end else begin : g_nopad
            assign ln = scan_line[4:0];
            assign lo = first_line[4:0];
            assign hi = last_line[4:0];
        end
    endgenerate

    always_comb begin
        hit.addr_hit = (cell_addr == cur_addr);
        hit.line_hit = line_in_window(ln, lo, hi);
        hit.enabled  = disp_en;
    end

endmodule

// File: rtl/text_cursor_gate.sv
module text_cursor_gate
    import tcg_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LINE_W    = 5,
    parameter int FAST_LOG2 = 4,
    parameter int SLOW_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_tick,
    input  logic [1:0]        mode,
    input  logic [LINE_W-1:0] first_line,
    input  logic [LINE_W-1:0] last_line,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] cell_addr,
    input  logic [LINE_W-1:0] scan_line,
    input  logic              disp_en,
    output logic              cursor_on
);
    blink_phase_t phase;
    cell_hit_t    hit;
    cur_mode_e    cmode;
    logic         mode_vis;
    logic         show_d;

    tcg_blink_gen #(
        .FAST_LOG2(FAST_LOG2),
        .SLOW_LOG2(SLOW_LOG2)
    ) u_blink (
        .clk       (clk),
        .rst       (rst),
        .frame_tick(frame_tick),
        .phase     (phase)
    );

    tcg_cell_match #(
        .ADDR_W(ADDR_W),
        .LINE_W(LINE_W)
    ) u_match (
        .cur_addr  (cur_addr),
        .cell_addr (cell_addr),
        .first_line(first_line),
        .last_line (last_line),
        .scan_line (scan_line),
        .disp_en   (disp_en),
        .hit       (hit)
    );

    always_comb begin
        cmode = cur_mode_e'(mode);
        unique case (cmode)
            CM_STEADY: mode_vis = 1'b1;
            CM_HIDDEN: mode_vis = 1'b0;
            CM_FAST:   mode_vis = phase.fast_vis;
            CM_SLOW:   mode_vis = phase.slow_vis;
            default:   mode_vis = 1'b0;
        endcase
        show_d = mode_vis & hit.addr_hit & hit.line_hit & hit.enabled;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cursor_on <= 1'b0;
        end else begin
            cursor_on <= show_d;
        end
    end

endmodule

// File: rtl/text_cursor_gate_chk.sv
module text_cursor_gate_chk #(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic [LINE_W-1:0] first_line,
    input logic [LINE_W-1:0] last_line,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [ADDR_W-1:0] cell_addr,
    input logic [LINE_W-1:0] scan_line,
    input logic              disp_en,
    input logic              cursor_on
);
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> !cursor_on);

    a_r3_hidden: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |=> !cursor_on);

    a_r6_addr_mismatch: assert property (@(posedge clk) disable iff (rst)
        (cell_addr != cur_addr) |=> !cursor_on);

    a_r7_outside_window: assert property (@(posedge clk) disable iff (rst)
        ((scan_line < first_line) || (scan_line > last_line)) |=> !cursor_on);

    a_r8_blanked: assert property (@(posedge clk) disable iff (rst)
        !disp_en |=> !cursor_on);

    a_r2_steady_shows: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'b00) && (cell_addr == cur_addr) && disp_en &&
         (scan_line >= first_line) && (scan_line <= last_line)) |=> cursor_on);

endmodule

bind text_cursor_gate text_cursor_gate_chk #(
    .ADDR_W(ADDR_W),
    .LINE_W(LINE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .first_line(first_line),
    .last_line (last_line),
    .cur_addr  (cur_addr),
    .cell_addr (cell_addr),
    .scan_line (scan_line),
    .disp_en   (disp_en),
    .cursor_on (cursor_on)
);

// File: tb/text_cursor_gate_bench.sv
`timescale 1ns/1ps
module text_cursor_gate_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_tick = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [4:0]  first_line = 5'd0;
    logic [4:0]  last_line = 5'd7;
    logic [15:0] cur_addr = 16'h0000;
    logic [15:0] cell_addr = 16'h0000;
    logic [4:0]  scan_line = 5'd0;
    logic        disp_en = 1'b0;
    logic        cursor_on;

    int checks = 0;
    int failures = 0;
    int model_cnt = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    text_cursor_gate u_text_cursor_gate (
        .clk       (clk),
        .rst       (rst),
        .frame_tick(frame_tick),
        .mode      (mode),
        .first_line(first_line),
        .last_line (last_line),
        .cur_addr  (cur_addr),
        .cell_addr (cell_addr),
        .scan_line (scan_line),
        .disp_en   (disp_en),
        .cursor_on (cursor_on)
    );

    function automatic logic model(input logic [1:0] m, input logic [15:0] a,
                                   input logic [4:0] ln, input logic en, input int cnt);
        logic vis;
        case (m)
            2'b00: vis = 1'b1;
            2'b01: vis = 1'b0;
            2'b10: vis = ((cnt % 16) < 8);
            default: vis = ((cnt % 32) < 16);
        endcase
        return vis && (a == cur_addr) && en && (ln >= first_line) && (ln <= last_line);
    endfunction

    task automatic drive(input logic [1:0] m, input logic [15:0] a, input logic [4:0] ln,
                         input logic en, input logic tk, input string tag);
        item_t it;
        @(negedge clk);
        mode = m; cell_addr = a; scan_line = ln; disp_en = en; frame_tick = tk;
        it.exp = model(m, a, ln, en, model_cnt);
        it.tag = tag;
        sb.push_back(it);
        if (tk) model_cnt = (model_cnt + 1) % 32;
        @(posedge clk);
        #1;
    endtask

    task automatic check_now(input logic exp, input string tag);
        checks++;
        if (cursor_on !== exp) begin
            failures++;
            $display("FAIL %s: cursor_on=%b expected=%b", tag, cursor_on, exp);
        end
    endtask

    // monitor
    always begin
        @(posedge clk);
        #5;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check_now(it.exp, it.tag);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: cycles=%0d expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset holds output low and clears frame count
        cur_addr = 16'h1234; cell_addr = 16'h1234; disp_en = 1'b1;
        first_line = 5'd2; last_line = 5'd5; scan_line = 5'd3; frame_tick = 1'b1;
        repeat (3) begin
            @(posedge clk); #5;
            check_now(1'b0, "R1 during reset");
        end
        @(negedge clk);
        rst = 1'b0; frame_tick = 1'b0; disp_en = 1'b0;
        model_cnt = 0;
        @(posedge clk); #5;
        check_now(1'b0, "R1 after reset");

        // R2 steady and R7 window boundaries
        drive(2'b00, 16'h1234, 5'd3, 1'b1, 1'b0, "R2 steady match");
        drive(2'b00, 16'h1234, 5'd2, 1'b1, 1'b0, "R7 first line inclusive");
        drive(2'b00, 16'h1234, 5'd5, 1'b1, 1'b0, "R7 last line inclusive");
        drive(2'b00, 16'h1234, 5'd1, 1'b1, 1'b0, "R7 above window");
        drive(2'b00, 16'h1234, 5'd6, 1'b1, 1'b0, "R7 below window");
        // R6 / R8 / R3
        drive(2'b00, 16'h1235, 5'd3, 1'b1, 1'b0, "R6 address mismatch");
        drive(2'b00, 16'h0234, 5'd3, 1'b1, 1'b0, "R6 high byte mismatch");
        drive(2'b00, 16'h1234, 5'd3, 1'b0, 1'b0, "R8 display disabled");
        drive(2'b01, 16'h1234, 5'd3, 1'b1, 1'b0, "R3 hidden");
        // R9 alternating latency
        for (int i = 0; i < 6; i++)
            drive(2'b00, (i % 2 == 0) ? 16'h1234 : 16'h4321, 5'd4, 1'b1, 1'b0, "R9 one-cycle latency");

        // R7 inverted and single-line windows
        first_line = 5'd6; last_line = 5'd3;
        drive(2'b00, 16'h1234, 5'd4, 1'b1, 1'b0, "R7 inverted window empty");
        drive(2'b00, 16'h1234, 5'd6, 1'b1, 1'b0, "R7 inverted window at first");
        first_line = 5'd0; last_line = 5'd0;
        drive(2'b00, 16'h1234, 5'd0, 1'b1, 1'b0, "R7 single line 0");
        drive(2'b00, 16'h1234, 5'd1, 1'b1, 1'b0, "R7 single line miss");
        first_line = 5'd0; last_line = 5'd31;
        drive(2'b00, 16'h1234, 5'd31, 1'b1, 1'b0, "R7 full window top");

        // R4 fast blink across more than two periods
        for (int i = 0; i < 40; i++)
            drive(2'b10, 16'h1234, 5'd7, 1'b1, 1'b1, "R4 fast blink");
        // R9/R4 count holds without ticks
        for (int i = 0; i < 4; i++)
            drive(2'b10, 16'h1234, 5'd7, 1'b1, 1'b0, "R9 no tick holds phase");
        // R5 slow blink across more than two periods
        for (int i = 0; i < 70; i++)
            drive(2'b11, 16'h1234, 5'd7, 1'b1, 1'b1, "R5 slow blink");
        // R2 steady and R3 hidden independent of frame count
        for (int i = 0; i < 20; i++)
            drive(2'b00, 16'h1234, 5'd7, 1'b1, 1'b1, "R2 steady over frames");
        for (int i = 0; i < 20; i++)
            drive(2'b01, 16'h1234, 5'd7, 1'b1, 1'b1, "R3 hidden over frames");

        // R1 reset mid-run clears frame count
        @(negedge clk);
        rst = 1'b1; frame_tick = 1'b0;
        @(posedge clk); #5;
        check_now(1'b0, "R1 mid-run reset");
        @(negedge clk);
        rst = 1'b0;
        model_cnt = 0;
        drive(2'b10, 16'h1234, 5'd7, 1'b1, 1'b0, "R1 count cleared, fast visible");
        drive(2'b11, 16'h1234, 5'd7, 1'b1, 1'b0, "R1 count cleared, slow visible");

        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule